// File: doc/BRIEF.md
# Scalar Floating-Point Negate Unit

This unit takes one 32-bit instruction word and carries out a scalar floating-point negate. It holds a file of thirty-two 128-bit vector registers. The size field in the word picks the element width: 16, 32 or 64 bits. The unit reads the source register and inverts the sign bit of its lowest element. It then writes the full 128-bit destination. A merge input decides what happens to the destination bits above the element: they either keep their old value or are cleared.

The unit accepts an instruction through a valid/ready handshake and completes it in one cycle. The register write and a one-cycle status pulse both come on the clock edge that accepts the instruction. The status pulse is exactly one of four: done, undefined, trap or not-recognized. A separate write port loads the register file, and a combinational read port reads it back. These two ports are how neighbouring logic shares the file. A load has priority over an instruction: while a load is pending, `in_ready_o` is low and the instruction waits.

Top module: `fneg_unit`

## Requirements
- R1: An instruction is recognised only when bits 31..24 equal 8'h1E, bit 21 is 1 and bits 20..10 equal 11'b00001010000. The recognised words are therefore 32'h1E214000 | size<<22 | src<<5 | dst. Any other accepted word pulses `unknown_o` and writes no register.
- R2: Size code 2'b00 is single precision. Bit 31 of the source is inverted into the destination, and bits 30..0 are copied unchanged.
- R3: Size code 2'b01 is double precision. Bit 63 is inverted, and bits 62..0 are copied unchanged.
- R4: Size code 2'b11 with `half_en_i` high is half precision. Bit 15 is inverted, and bits 14..0 are copied unchanged.
- R5: Size code 2'b10 is reserved. It pulses `undef_o` and writes no register.
- R6: Size code 2'b11 with `half_en_i` low pulses `undef_o` and writes no register.
- R7: With `merge_i` high, destination bits above the element keep their previous contents. With `merge_i` low, those bits are written as zero.
- R8: With `fp_en_i` low, a recognised and defined word pulses `trap_o` and writes no register. An undefined word still reports `undef_o` rather than `trap_o`.
- R9: Only the sign bit changes. Zeros, infinities and NaNs keep their exponent and fraction exactly, including a NaN payload.
- R10: When the source and destination indices are equal, merging keeps the upper bits of that same register.
- R11: The register write and exactly one status pulse occur on the edge that accepts the instruction. No status output is high in a cycle that follows a clock edge with no acceptance.
- R12: While `ld_en_i` is high, `in_ready_o` is low and the load writes the register file. An instruction held during the load is accepted afterwards and reads the loaded value.
- R13: After reset, every register reads zero, all status outputs are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Instruction word valid |
| in_ready_o | output | 1 | Unit can accept an instruction |
| instr_i | input | 32 | Instruction word |
| fp_en_i | input | 1 | Floating-point access enabled |
| half_en_i | input | 1 | Half-precision support present |
| merge_i | input | 1 | 1: keep upper destination bits, 0: clear them |
| ld_en_i | input | 1 | Register load strobe |
| ld_idx_i | input | 5 | Register load index |
| ld_data_i | input | 128 | Register load data |
| rd_idx_i | input | 5 | Read-back index |
| rd_data_o | output | 128 | Read-back data (combinational) |
| done_o | output | 1 | Negate completed and written |
| undef_o | output | 1 | Undefined encoding |
| trap_o | output | 1 | Floating-point access disabled |
| unknown_o | output | 1 | Word not recognised by this unit |

## Verification
Two functions can fall in the same cycle: a register load and an instruction issue. Both want the single write port. The bench raises `ld_en_i` and `in_valid_i` together, with the load aimed at the register the instruction will read as its source. It first checks that `in_ready_o` is low and that no status pulse follows the load edge. It then checks that the held instruction completes one cycle later and produces the negation of the freshly loaded value, not the stale one.

// File: rtl/fneg_pkg.sv
package fneg_pkg;
  localparam int unsigned VLEN      = 128;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned NREGS     = 1 << REG_IDX_W;

  typedef enum logic [1:0] {
    SZ_SGL = 2'b00,
    SZ_DBL = 2'b01,
    SZ_RSV = 2'b10,
    SZ_HLF = 2'b11
  } fsize_e;

  // element width = 8 << (code ^ 2'b10)
  function automatic int unsigned elem_bits(fsize_e sz);
    return 8 << (int'(sz) ^ 2);
  endfunction
endpackage

// File: rtl/fneg_decode.sv
module fneg_decode
  import fneg_pkg::*;
(
  input  logic [31:0]          instr_i,
  input  logic                 half_en_i,
  output logic                 match_o,
  output logic                 undef_o,
  output fsize_e               size_o,
  output logic [REG_IDX_W-1:0] rn_o,
  output logic [REG_IDX_W-1:0] rd_o
);
  localparam logic [7:0]  OPC_HI = 8'h1E;
  localparam logic [10:0] OPC_LO = 11'b00001010000;

  assign match_o = (instr_i[31:24] == OPC_HI) && instr_i[21] && (instr_i[20:10] == OPC_LO);
  assign size_o  = fsize_e'(instr_i[23:22]);
  assign rn_o    = instr_i[5 +: REG_IDX_W];
  assign rd_o    = instr_i[0 +: REG_IDX_W];
  assign undef_o = (size_o == SZ_RSV) || ((size_o == SZ_HLF) && !half_en_i);
endmodule

// File: rtl/fneg_exec.sv
module fneg_exec
  import fneg_pkg::*;
#(
  parameter int unsigned W = VLEN
) (
  input  fsize_e       size_i,
  input  logic         merge_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] old_i,
  output logic [W-1:0] res_o
);
  int unsigned esz;
  logic [W-1:0] lane_m;
  logic [W-1:0] sign_m;

  assign esz = elem_bits(size_i);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign lane_m[b] = (b < esz);
    assign sign_m[b] = (b == esz - 1);
  end

  always_comb begin
    res_o = ((src_i & lane_m) ^ sign_m);
    if (merge_i) res_o = res_o | (old_i & ~lane_m);
  end
endmodule

// File: rtl/fneg_regfile.sv
module fneg_regfile
  import fneg_pkg::*;
#(
  parameter int unsigned W = VLEN,
  parameter int unsigned N = NREGS,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra0_i,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd0_o,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o
);
  logic [W-1:0] mem_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[i] <= '0;
      else if (we_i && wa_i == AW'(i))     mem_q[i] <= wd_i;
    end
  end

  assign rd0_o = mem_q[ra0_i];
  assign rd1_o = mem_q[ra1_i];
  assign rd2_o = mem_q[ra2_i];
endmodule

// File: rtl/fneg_unit.sv
module fneg_unit
  import fneg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [31:0]          instr_i,
  input  logic                 fp_en_i,
  input  logic                 half_en_i,
  input  logic                 merge_i,
  input  logic                 ld_en_i,
  input  logic [REG_IDX_W-1:0] ld_idx_i,
  input  logic [VLEN-1:0]      ld_data_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  output logic [VLEN-1:0]      rd_data_o,
  output logic                 done_o,
  output logic                 undef_o,
  output logic                 trap_o,
  output logic                 unknown_o
);
  logic                 acc, match, undef, exec_we;
  fsize_e               size;
  logic [REG_IDX_W-1:0] rn, rd, wa;
  logic [VLEN-1:0]      src, old, res, wd;

  assign in_ready_o = !ld_en_i;
  assign acc        = in_valid_i && in_ready_o;

  fneg_decode i_dec (
    .instr_i  (instr_i),
    .half_en_i(half_en_i),
    .match_o  (match),
    .undef_o  (undef),
    .size_o   (size),
    .rn_o     (rn),
    .rd_o     (rd)
  );

  fneg_exec #(.W(VLEN)) i_exe (
    .size_i (size),
    .merge_i(merge_i),
    .src_i  (src),
    .old_i  (old),
    .res_o  (res)
  );

  // decode faults outrank the enable check
  assign exec_we = acc && match && !undef && fp_en_i;
  assign wa      = ld_en_i ? ld_idx_i  : rd;
  assign wd      = ld_en_i ? ld_data_i : res;

  fneg_regfile #(.W(VLEN), .N(NREGS)) i_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (ld_en_i || exec_we),
    .wa_i  (wa),
    .wd_i  (wd),
    .ra0_i (rn),
    .ra1_i (rd),
    .ra2_i (rd_idx_i),
    .rd0_o (src),
    .rd1_o (old),
    .rd2_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      undef_o   <= 1'b0;
      trap_o    <= 1'b0;
      unknown_o <= 1'b0;
    end else begin
      done_o    <= exec_we;
      unknown_o <= acc && !match;
      undef_o   <= acc && match && undef;
      trap_o    <= acc && match && !undef && !fp_en_i;
    end
  end
endmodule

// File: rtl/fneg_unit_checks.sv
module fneg_unit_checks (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [31:0] instr_i,
  input logic        fp_en_i,
  input logic        ld_en_i,
  input logic        done_o,
  input logic        undef_o,
  input logic        trap_o,
  input logic        unknown_o
);
  logic acc, hit;
  assign acc = in_valid_i && in_ready_o;
  assign hit = acc && instr_i[31:24] == 8'h1E && instr_i[21] && instr_i[20:10] == 11'b00001010000;

  p_ld_stall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |-> !in_ready_o);

  p_one_status_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, undef_o, trap_o, unknown_o}));

  p_quiet_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !(done_o || undef_o || trap_o || unknown_o));

  p_foreign_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && instr_i[31:24] != 8'h1E) |=> unknown_o);

  p_reserved_size_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && instr_i[23:22] == 2'b10) |=> undef_o);

  p_disabled_trap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && instr_i[23] == 1'b0 && !fp_en_i) |=> trap_o);
endmodule

bind fneg_unit fneg_unit_checks i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .instr_i   (instr_i),
  .fp_en_i   (fp_en_i),
  .ld_en_i   (ld_en_i),
  .done_o    (done_o),
  .undef_o   (undef_o),
  .trap_o    (trap_o),
  .unknown_o (unknown_o)
);

// File: tb/test_fneg_unit.sv
module test_fneg_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [31:0]  instr_i = '0;
  logic         fp_en_i = 1'b1, half_en_i = 1'b1, merge_i = 1'b0;
  logic         ld_en_i = 1'b0;
  logic [4:0]   ld_idx_i = '0, rd_idx_i = '0;
  logic [127:0] ld_data_i = '0, rd_data_o;
  logic         done_o, undef_o, trap_o, unknown_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  fneg_unit i_fneg_unit (.*);

  // kind: 0 done, 1 undef, 2 trap, 3 unknown
  typedef struct packed {
    logic [127:0] src;
    logic [127:0] dst;
    logic [4:0]   rn;
    logic [4:0]   rd;
    logic [1:0]   sz;
    logic         mg;
    logic         fen;
    logic         hen;
    logic [1:0]   kind;
    logic [127:0] exp;
    logic [3:0]   req;
  } vec_t;

  localparam logic [127:0] SRC = 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF;
  localparam logic [127:0] OLD = {32{4'hA}};
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{SRC, OLD, 5'd3, 5'd7, 2'b00, 1'b1, 1'b1, 1'b1, 2'd0, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_09AB_CDEF, 4'd2},  // R2 R7
    '{SRC, OLD, 5'd3, 5'd7, 2'b00, 1'b0, 1'b1, 1'b1, 2'd0, 128'h0000_0000_0000_0000_0000_0000_09AB_CDEF, 4'd7},  // R7
    '{SRC, OLD, 5'd3, 5'd7, 2'b01, 1'b1, 1'b1, 1'b1, 2'd0, 128'hAAAA_AAAA_AAAA_AAAA_8123_4567_89AB_CDEF, 4'd3},  // R3
    '{SRC, OLD, 5'd3, 5'd7, 2'b01, 1'b0, 1'b1, 1'b1, 2'd0, 128'h0000_0000_0000_0000_8123_4567_89AB_CDEF, 4'd3},  // R3
    '{SRC, OLD, 5'd3, 5'd7, 2'b11, 1'b1, 1'b1, 1'b1, 2'd0, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_4DEF, 4'd4},  // R4
    '{SRC, OLD, 5'd3, 5'd7, 2'b11, 1'b0, 1'b1, 1'b1, 2'd0, 128'h0000_0000_0000_0000_0000_0000_0000_4DEF, 4'd4},  // R4
    '{SRC, OLD, 5'd3, 5'd7, 2'b10, 1'b1, 1'b1, 1'b1, 2'd1, OLD, 4'd5},                                          // R5
    '{SRC, OLD, 5'd3, 5'd7, 2'b11, 1'b1, 1'b1, 1'b0, 2'd1, OLD, 4'd6},                                          // R6
    '{SRC, OLD, 5'd3, 5'd7, 2'b00, 1'b1, 1'b0, 1'b1, 2'd2, OLD, 4'd8},                                          // R8
    '{SRC, OLD, 5'd3, 5'd7, 2'b10, 1'b1, 1'b0, 1'b1, 2'd1, OLD, 4'd8},                                          // R8 undef wins
    '{128'h7FC0_1234, OLD, 5'd3, 5'd7, 2'b00, 1'b0, 1'b1, 1'b1, 2'd0, 128'hFFC0_1234, 4'd9},                    // R9 NaN
    '{128'h8000_0000_0000_0000, OLD, 5'd3, 5'd7, 2'b01, 1'b1, 1'b1, 1'b1, 2'd0,
      128'hAAAA_AAAA_AAAA_AAAA_0000_0000_0000_0000, 4'd9},                                                    // R9 -0
    '{128'h7C00, OLD, 5'd3, 5'd7, 2'b11, 1'b0, 1'b1, 1'b1, 2'd0, 128'hFC00, 4'd9},                              // R9 inf
    '{SRC, SRC, 5'd9, 5'd9, 2'b00, 1'b1, 1'b1, 1'b1, 2'd0, 128'hFEDC_BA98_7654_3210_0123_4567_09AB_CDEF, 4'd10} // R10
  };

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load(logic [4:0] idx, logic [127:0] d);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = d;
    @(negedge clk_i);
    ld_en_i = 1'b0;
  endtask

  function automatic logic [31:0] enc(logic [1:0] sz, logic [4:0] rn, logic [4:0] rd);
    return 32'h1E21_4000 | (32'(sz) << 22) | (32'(rn) << 5) | 32'(rd);
  endfunction

  // drive for one edge, then sample status at the next falling edge
  task automatic issue(logic [31:0] w, output logic [3:0] st);
    @(negedge clk_i);
    in_valid_i = 1'b1; instr_i = w;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    st = {unknown_o, trap_o, undef_o, done_o};
  endtask

  logic [3:0] st;

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R13 reset state
    rd_idx_i = 5'd0;  #1 chk("R13 reg0", rd_data_o, '0);
    rd_idx_i = 5'd31; #1 chk("R13 reg31", rd_data_o, '0);
    chk("R13 status/ready", {123'd0, unknown_o, trap_o, undef_o, done_o, in_ready_o}, 128'd1);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].rd, VEC[i].dst);
      load(VEC[i].rn, VEC[i].src);
      merge_i = VEC[i].mg; fp_en_i = VEC[i].fen; half_en_i = VEC[i].hen;
      issue(enc(VEC[i].sz, VEC[i].rn, VEC[i].rd), st);
      chk($sformatf("R%0d status v%0d", VEC[i].req, i), 128'(st), 128'(4'b0001 << VEC[i].kind));
      rd_idx_i = VEC[i].rd; #1;
      chk($sformatf("R%0d data v%0d", VEC[i].req, i), rd_data_o, VEC[i].exp);
    end
    merge_i = 1'b1; fp_en_i = 1'b1; half_en_i = 1'b1;

    // R1 fixed field broken at bit 15
    load(5'd7, OLD);
    issue(enc(2'b00, 5'd3, 5'd7) ^ 32'h0000_8000, st);
    chk("R1 status", 128'(st), 128'(4'b1000));
    rd_idx_i = 5'd7; #1 chk("R1 no write", rd_data_o, OLD);
    issue(32'h0000_0000, st);
    chk("R1 zero word", 128'(st), 128'(4'b1000));

    // R11 no pulse after an idle edge
    @(negedge clk_i);
    chk("R11 idle", 128'({unknown_o, trap_o, undef_o, done_o}), '0);

    // R12 load and issue collide; load targets the source register
    load(5'd6, OLD);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_idx_i = 5'd5; ld_data_i = 128'h1234_5678;
    in_valid_i = 1'b1; instr_i = enc(2'b00, 5'd5, 5'd6);
    #1 chk("R12 ready low", 128'(in_ready_o), 128'd0);
    @(negedge clk_i);
    ld_en_i = 1'b0;
    chk("R12 held no status", 128'({unknown_o, trap_o, undef_o, done_o}), '0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R12 done after load", 128'(done_o), 128'd1);
    rd_idx_i = 5'd6; #1;
    chk("R12 fresh source", rd_data_o, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_9234_5678);
    rd_idx_i = 5'd5; #1 chk("R12 load kept", rd_data_o, 128'h1234_5678);
    @(negedge clk_i);
    chk("R11 single pulse", 128'(done_o), 128'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule